// File: doc/BRIEF.md
# Multi-channel DMA register front end

This block is the software-visible register file of a small DMA controller with a parameterized number of channels. A 32-bit register bus with separate write and read strobes reaches one shared command word and one register bank per channel. A single write to the command word can launch or cancel any set of channels. Each set channel bit produces a one-cycle pulse towards that channel's transfer engine.

Each bank holds the channel's programming: source and destination mode, source and destination address, and byte count. These values drive the transfer engine continuously. The engine reports two events back: transfer finished, and cancel accepted. Each bank offers four views of those events:

- the live event lines;
- a sticky copy that software clears by writing ones;
- an enable mask;
- the sticky copy gated by the mask.

Each channel has its own interrupt output. It is driven from the masked view, so several channels can share one interrupt line and software can still find the channel that fired.

Top module: `dma_regfront`

## Requirements
- R1: After reset all mode, address, size, enable and sticky-status fields read zero and drive zero. All interrupt outputs are low and no start or abort pulse is produced.
- R2: A write to offset 0x000 with bit 31 clear drives `ch_start[n]` high for exactly the one cycle after the write, for every n whose data bit n is 1. `ch_abort` stays low.
- R3: A write to offset 0x000 with bit 31 set drives `ch_abort[n]` instead, with the same selection and timing. `ch_start` stays low.
- R4: Offset 0x000 always reads as zero.
- R5: Channel n's bank starts at 0x100 + 0x40·n. Within a bank the fields sit at these offsets:
  - 0x20 source mode (low MODE_W bits kept);
  - 0x24 destination mode (low MODE_W bits kept);
  - 0x28 source address;
  - 0x2C destination address;
  - 0x30 byte count.

  Each field reads back what was written and drives the matching output slice from the cycle after the write.
- R6: Bank offset 0x10 returns the event inputs present in the read cycle: bit 1 is done and bit 13 is abort-acknowledge. Writes to it have no effect.
- R7: Bank offset 0x14 holds sticky copies of the events, in bits 1 and 13. Writing a 1 to a bit clears that bit.
- R8: When an event and a write-1-to-clear hit the same sticky bit in the same cycle, the bit ends up set.
- R9: Bank offset 0x18 is an enable mask for bits 1 and 13. Bank offset 0x1C reads the sticky bits ANDed with the mask and is read-only.
- R10: `irq[n]` is high exactly while channel n's masked status is nonzero, independent of the other channels.
- R11: Reads of unmapped offsets return zero. This covers other offsets in the command area, other offsets within a bank, and addresses past the last bank. Writes to unmapped offsets change no state and produce no pulse.
- R12: Read data appears on `reg_rdata` in the cycle after `reg_rd` is sampled high. It holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| ch_start | output | NUM_CH | One-cycle start pulse per channel |
| ch_abort | output | NUM_CH | One-cycle abort pulse per channel |
| ch_src_mode | output | NUM_CH*MODE_W | Source mode per channel |
| ch_dst_mode | output | NUM_CH*MODE_W | Destination mode per channel |
| ch_src_addr | output | NUM_CH*32 | Source address per channel |
| ch_dst_addr | output | NUM_CH*32 | Destination address per channel |
| ch_xfer_size | output | NUM_CH*32 | Byte count per channel |
| evt_done | input | NUM_CH | Transfer-finished event per channel |
| evt_abort_ack | input | NUM_CH | Cancel-accepted event per channel |
| irq | output | NUM_CH | Interrupt per channel |

## Verification
The command word is written with a multi-bit start selection and with a single-bit abort selection. This separates the two pulse buses and shows that only the selected channels fire. Events are injected:

- on one channel while another channel's mask is open, so a fault in the channel indexing of the interrupts shows up;
- together with a clearing write, which tells set-priority apart from clear-priority and shows that the other sticky bit is still cleared.

Field writes to different banks, followed by reads of offsets just outside the map, separate correct bank decoding from aliasing.

// File: rtl/dma_regfront_pkg.sv
package dma_regfront_pkg;
  localparam int unsigned CMD_OFS     = 'h000;
  localparam int unsigned BANK_BASE   = 'h100;
  localparam int unsigned BANK_STRIDE = 'h40;
  localparam int unsigned OFS_RAW     = 'h10;
  localparam int unsigned OFS_LAT     = 'h14;
  localparam int unsigned OFS_EN      = 'h18;
  localparam int unsigned OFS_MSK     = 'h1C;
  localparam int unsigned OFS_SMODE   = 'h20;
  localparam int unsigned OFS_DMODE   = 'h24;
  localparam int unsigned OFS_SADDR   = 'h28;
  localparam int unsigned OFS_DADDR   = 'h2C;
  localparam int unsigned OFS_SIZE    = 'h30;
  localparam int unsigned BIT_DONE    = 1;
  localparam int unsigned BIT_ABORT   = 13;
  localparam int unsigned BIT_CMD_ABT = 31;

  typedef struct packed {
    logic abort;
    logic done;
  } evt_t;

  function automatic logic [31:0] evt_to_word(evt_t e);
    logic [31:0] w;
    w = '0;
    w[BIT_DONE]  = e.done;
    w[BIT_ABORT] = e.abort;
    return w;
  endfunction
endpackage

// File: rtl/dma_regfront_cmd.sv
module dma_regfront_cmd #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              cmd_abort_flag,
  input  logic [NUM_CH-1:0] cmd_sel,
  output logic [NUM_CH-1:0] start_o,
  output logic [NUM_CH-1:0] abort_o
);
  logic [NUM_CH-1:0] start_d, abort_d, start_q, abort_q;

  always_comb begin
    start_d = '0;
    abort_d = '0;
    if (cmd_wr) begin
      if (cmd_abort_flag) abort_d = cmd_sel;
      else                start_d = cmd_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      abort_q <= '0;
    end else begin
      start_q <= start_d;
      abort_q <= abort_d;
    end
  end

  assign start_o = start_q;
  assign abort_o = abort_q;

  // R2: a start pulse only follows a start command write
  p_start_from_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|start_q) |-> $past(cmd_wr && !cmd_abort_flag));
  // R3: abort and start never fire together
  p_abort_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|abort_q) |-> (start_q == '0));
  // R2: pulses last one cycle without a new write
  p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((|start_q) && !cmd_wr) |=> (start_q == '0));
endmodule

// File: rtl/dma_regfront_chan.sv
module dma_regfront_chan
  import dma_regfront_pkg::*;
#(
  parameter int MODE_W = 8,
  parameter int OFS_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_wr,
  input  logic [OFS_W-1:0]  bank_off,
  input  logic [31:0]       wdata,
  input  logic              evt_done,
  input  logic              evt_abort_ack,
  output logic [31:0]       rd_val,
  output logic [MODE_W-1:0] src_mode,
  output logic [MODE_W-1:0] dst_mode,
  output logic [31:0]       src_addr,
  output logic [31:0]       dst_addr,
  output logic [31:0]       xfer_size,
  output logic              irq
);
  localparam logic [OFS_W-1:0] L_RAW   = OFS_W'(OFS_RAW);
  localparam logic [OFS_W-1:0] L_LAT   = OFS_W'(OFS_LAT);
  localparam logic [OFS_W-1:0] L_EN    = OFS_W'(OFS_EN);
  localparam logic [OFS_W-1:0] L_MSK   = OFS_W'(OFS_MSK);
  localparam logic [OFS_W-1:0] L_SMODE = OFS_W'(OFS_SMODE);
  localparam logic [OFS_W-1:0] L_DMODE = OFS_W'(OFS_DMODE);
  localparam logic [OFS_W-1:0] L_SADDR = OFS_W'(OFS_SADDR);
  localparam logic [OFS_W-1:0] L_DADDR = OFS_W'(OFS_DADDR);
  localparam logic [OFS_W-1:0] L_SIZE  = OFS_W'(OFS_SIZE);

  logic [MODE_W-1:0] smode_q, dmode_q;
  logic [31:0]       saddr_q, daddr_q, size_q;
  evt_t              sts_q, sts_d, en_q, sts_set, sts_clr, msk;
  logic              wr_smode, wr_dmode, wr_saddr, wr_daddr, wr_size, wr_en, wr_lat;

  always_comb begin
    wr_smode = bank_wr && (bank_off == L_SMODE);
    wr_dmode = bank_wr && (bank_off == L_DMODE);
    wr_saddr = bank_wr && (bank_off == L_SADDR);
    wr_daddr = bank_wr && (bank_off == L_DADDR);
    wr_size  = bank_wr && (bank_off == L_SIZE);
    wr_en    = bank_wr && (bank_off == L_EN);
    wr_lat   = bank_wr && (bank_off == L_LAT);
    sts_set  = '{abort: evt_abort_ack, done: evt_done};
    sts_clr  = '{abort: wr_lat && wdata[BIT_ABORT], done: wr_lat && wdata[BIT_DONE]};
    sts_d    = (sts_q & ~sts_clr) | sts_set;
    msk      = sts_q & en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smode_q <= '0;
      dmode_q <= '0;
      saddr_q <= '0;
      daddr_q <= '0;
      size_q  <= '0;
      en_q    <= '0;
      sts_q   <= '0;
    end else begin
      if (wr_smode) smode_q <= wdata[MODE_W-1:0];
      if (wr_dmode) dmode_q <= wdata[MODE_W-1:0];
      if (wr_saddr) saddr_q <= wdata;
      if (wr_daddr) daddr_q <= wdata;
      if (wr_size)  size_q  <= wdata;
      if (wr_en)    en_q    <= '{abort: wdata[BIT_ABORT], done: wdata[BIT_DONE]};
      sts_q <= sts_d;
    end
  end

  always_comb begin
    case (bank_off)
      L_RAW:   rd_val = evt_to_word(sts_set);
      L_LAT:   rd_val = evt_to_word(sts_q);
      L_EN:    rd_val = evt_to_word(en_q);
      L_MSK:   rd_val = evt_to_word(msk);
      L_SMODE: rd_val = 32'(smode_q);
      L_DMODE: rd_val = 32'(dmode_q);
      L_SADDR: rd_val = saddr_q;
      L_DADDR: rd_val = daddr_q;
      L_SIZE:  rd_val = size_q;
      default: rd_val = '0;
    endcase
  end

  assign src_mode  = smode_q;
  assign dst_mode  = dmode_q;
  assign src_addr  = saddr_q;
  assign dst_addr  = daddr_q;
  assign xfer_size = size_q;
  assign irq       = |msk;

  // R8: an event always leaves its sticky bit set
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(evt_done && rst_n) |-> sts_q.done);
  // R7: a clearing write without a coincident event clears the bit
  p_clear_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_lat && wdata[BIT_DONE] && !evt_done && rst_n) |-> !sts_q.done);
  // R10: interrupt requires an open mask bit
  p_irq_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en_q != '0));
  // R5: fields change only on their own write
  p_saddr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_saddr) |-> $stable(saddr_q));
endmodule

// File: rtl/dma_regfront.sv
module dma_regfront
  import dma_regfront_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 12,
  parameter int MODE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic                     reg_rd,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  output logic [NUM_CH-1:0]        ch_start,
  output logic [NUM_CH-1:0]        ch_abort,
  output logic [NUM_CH*MODE_W-1:0] ch_src_mode,
  output logic [NUM_CH*MODE_W-1:0] ch_dst_mode,
  output logic [NUM_CH*32-1:0]     ch_src_addr,
  output logic [NUM_CH*32-1:0]     ch_dst_addr,
  output logic [NUM_CH*32-1:0]     ch_xfer_size,
  input  logic [NUM_CH-1:0]        evt_done,
  input  logic [NUM_CH-1:0]        evt_abort_ack,
  output logic [NUM_CH-1:0]        irq
);
  localparam int          OFS_W    = $clog2(BANK_STRIDE);
  localparam int unsigned BANK_END = BANK_BASE + NUM_CH * BANK_STRIDE;

  logic [31:0]       addr_ext, rel, rd_any, rdata_d, rdata_q;
  logic              in_bank, cmd_hit;
  logic [NUM_CH-1:0] bank_match;
  logic [31:0]       ch_rd [NUM_CH];

  always_comb begin
    addr_ext = 32'(reg_addr);
    in_bank  = (addr_ext >= BANK_BASE) && (addr_ext < BANK_END);
    cmd_hit  = (addr_ext == CMD_OFS);
    rel      = addr_ext - BANK_BASE;
  end

  dma_regfront_cmd #(.NUM_CH(NUM_CH)) u_cmd (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_wr         (reg_wr && cmd_hit),
    .cmd_abort_flag (reg_wdata[BIT_CMD_ABT]),
    .cmd_sel        (reg_wdata[NUM_CH-1:0]),
    .start_o        (ch_start),
    .abort_o        (ch_abort)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign bank_match[g] = in_bank && ((rel >> OFS_W) == 32'(g));
    dma_regfront_chan #(.MODE_W(MODE_W), .OFS_W(OFS_W)) u_chan (
      .clk           (clk),
      .rst_n         (rst_n),
      .bank_wr       (reg_wr && bank_match[g]),
      .bank_off      (rel[OFS_W-1:0]),
      .wdata         (reg_wdata),
      .evt_done      (evt_done[g]),
      .evt_abort_ack (evt_abort_ack[g]),
      .rd_val        (ch_rd[g]),
      .src_mode      (ch_src_mode[g*MODE_W +: MODE_W]),
      .dst_mode      (ch_dst_mode[g*MODE_W +: MODE_W]),
      .src_addr      (ch_src_addr[g*32 +: 32]),
      .dst_addr      (ch_dst_addr[g*32 +: 32]),
      .xfer_size     (ch_xfer_size[g*32 +: 32]),
      .irq           (irq[g])
    );
  end

  always_comb begin
    rd_any = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (bank_match[i]) rd_any = rd_any | ch_rd[i];
    rdata_d = reg_rd ? rd_any : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign reg_rdata = rdata_q;

  // R11 and R4: reads outside the banks return zero
  p_unmapped_read_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_rd && !in_bank && rst_n) |-> (reg_rdata == '0));
  // R12: read data holds without a read
  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!reg_rd && rst_n) |-> $stable(reg_rdata));
  // R11: a write outside every mapped location produces no pulse
  p_no_pulse_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_wr && !cmd_hit && rst_n) |-> ((ch_start | ch_abort) == '0));
endmodule

// File: tb/dma_regfront_tb.sv
module dma_regfront_tb;
  localparam int NUM_CH = 4;
  localparam int ADDR_W = 12;
  localparam int MODE_W = 8;

  logic                     clk, rst_n, reg_wr, reg_rd;
  logic [ADDR_W-1:0]        reg_addr;
  logic [31:0]              reg_wdata, reg_rdata;
  logic [NUM_CH-1:0]        ch_start, ch_abort, evt_done, evt_abort_ack, irq;
  logic [NUM_CH*MODE_W-1:0] ch_src_mode, ch_dst_mode;
  logic [NUM_CH*32-1:0]     ch_src_addr, ch_dst_addr, ch_xfer_size;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  logic rd_seen;
  logic [31:0] exp_q[$];
  string tag_q[$];

  dma_regfront #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .MODE_W(MODE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ch_start(ch_start), .ch_abort(ch_abort),
    .ch_src_mode(ch_src_mode), .ch_dst_mode(ch_dst_mode),
    .ch_src_addr(ch_src_addr), .ch_dst_addr(ch_dst_addr),
    .ch_xfer_size(ch_xfer_size),
    .evt_done(evt_done), .evt_abort_ack(evt_abort_ack), .irq(irq)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp,
                    input string tag);
    reg_rd = 1; reg_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    reg_rd = 0;
  endtask

  // monitor: pops the expected word for each completed read
  always @(posedge clk) rd_seen <= rst_n && reg_rd;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(reg_rdata === e, t, reg_rdata, e);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
    evt_done = '0; evt_abort_ack = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check(irq == 0, "R1 irq", 32'(irq), 0);
    check((ch_start | ch_abort) == 0, "R1 pulses", 32'(ch_start | ch_abort), 0);
    check(ch_src_addr == 0 && ch_xfer_size == 0 && ch_src_mode == 0,
          "R1 fields", ch_src_addr[31:0], 0);
    rd(12'h114, 32'h0, "R1 latched");
    rd(12'h118, 32'h0, "R1 enable");
    rd(12'h1F0, 32'h0, "R1 size ch3");

    // R2 start pulse on channels 0 and 2
    wr(12'h000, 32'h0000_0005);
    check(ch_start == 4'b0101, "R2 start", 32'(ch_start), 32'h5);
    check(ch_abort == 0, "R2 no abort", 32'(ch_abort), 0);
    @(negedge clk);
    check(ch_start == 0, "R2 one cycle", 32'(ch_start), 0);

    // R3 abort pulse on channel 1
    wr(12'h000, 32'h8000_0002);
    check(ch_abort == 4'b0010, "R3 abort", 32'(ch_abort), 32'h2);
    check(ch_start == 0, "R3 no start", 32'(ch_start), 0);
    @(negedge clk);
    check(ch_abort == 0, "R3 one cycle", 32'(ch_abort), 0);

    // R4 command reads zero
    rd(12'h000, 32'h0, "R4 cmd read");

    // R5 fields in bank 1 and bank 0
    wr(12'h160, 32'hFFFF_FF21);
    wr(12'h164, 32'h0000_0043);
    wr(12'h168, 32'hDEAD_BEEF);
    wr(12'h16C, 32'h1234_5678);
    wr(12'h170, 32'h0000_0200);
    wr(12'h128, 32'hA5A5_0000);
    check(ch_src_mode[15:8] == 8'h21, "R5 smode out", 32'(ch_src_mode[15:8]), 32'h21);
    check(ch_dst_mode[15:8] == 8'h43, "R5 dmode out", 32'(ch_dst_mode[15:8]), 32'h43);
    check(ch_src_addr[63:32] == 32'hDEAD_BEEF, "R5 saddr out", ch_src_addr[63:32], 32'hDEAD_BEEF);
    check(ch_dst_addr[63:32] == 32'h1234_5678, "R5 daddr out", ch_dst_addr[63:32], 32'h1234_5678);
    check(ch_xfer_size[63:32] == 32'h200, "R5 size out", ch_xfer_size[63:32], 32'h200);
    check(ch_src_addr[31:0] == 32'hA5A5_0000, "R5 ch0 saddr out", ch_src_addr[31:0], 32'hA5A5_0000);
    rd(12'h160, 32'h21, "R5 smode read");
    rd(12'h168, 32'hDEAD_BEEF, "R5 saddr read");
    rd(12'h170, 32'h200, "R5 size read");
    rd(12'h1A8, 32'h0, "R5 ch2 saddr untouched");

    // R6 raw view during an event, write ignored
    reg_rd = 1; reg_addr = 12'h110; evt_done[0] = 1;
    exp_q.push_back(32'h2); tag_q.push_back("R6 raw");
    @(negedge clk);
    reg_rd = 0; evt_done[0] = 0;
    wr(12'h110, 32'hFFFF_FFFF);
    rd(12'h110, 32'h0, "R6 raw idle");

    // R7 sticky copy, masked view closed
    rd(12'h114, 32'h2, "R7 latched done");
    rd(12'h11C, 32'h0, "R9 masked closed");
    check(irq == 0, "R10 irq masked off", 32'(irq), 0);

    // R9 R10 open mask
    wr(12'h118, 32'h0000_2002);
    rd(12'h118, 32'h2002, "R9 enable read");
    rd(12'h11C, 32'h2, "R9 masked");
    check(irq == 4'b0001, "R10 irq ch0", 32'(irq), 1);

    // R7 clear
    wr(12'h114, 32'h0000_0002);
    check(irq == 0, "R10 irq cleared", 32'(irq), 0);
    rd(12'h114, 32'h0, "R7 cleared");

    // R8 abort set, then clear-all with a coincident done
    evt_abort_ack[0] = 1; @(negedge clk); evt_abort_ack[0] = 0;
    rd(12'h114, 32'h2000, "R7 latched abort");
    evt_done[0] = 1;
    wr(12'h114, 32'h0000_2002);
    evt_done[0] = 0;
    rd(12'h114, 32'h2, "R8 set wins");
    wr(12'h114, 32'h0000_2002);

    // R10 per-channel independence: ch2 event, ch0 mask open, ch2 closed
    evt_done[2] = 1; @(negedge clk); evt_done[2] = 0;
    check(irq == 0, "R10 ch2 masked", 32'(irq), 0);
    wr(12'h198, 32'h0000_0002);
    check(irq == 4'b0100, "R10 ch2 irq", 32'(irq), 32'h4);
    rd(12'h19C, 32'h2, "R9 ch2 masked");
    wr(12'h194, 32'h0000_0002);
    check(irq == 0, "R10 ch2 cleared", 32'(irq), 0);

    // R11 unmapped
    wr(12'h200, 32'h0000_1234);
    wr(12'h134, 32'h0000_5678);
    wr(12'h004, 32'h0000_000F);
    check((ch_start | ch_abort) == 0, "R11 no pulse", 32'(ch_start | ch_abort), 0);
    rd(12'h200, 32'h0, "R11 past banks");
    rd(12'h134, 32'h0, "R11 bank hole");
    rd(12'h004, 32'h0, "R11 cmd area");
    rd(12'h128, 32'hA5A5_0000, "R11 ch0 saddr kept");
    rd(12'h1E0, 32'h0, "R11 ch3 smode kept");

    // R12 hold between reads
    rd(12'h168, 32'hDEAD_BEEF, "R12 read");
    reg_addr = 12'h170;
    idle(2);
    check(reg_rdata == 32'hDEAD_BEEF, "R12 hold", reg_rdata, 32'hDEAD_BEEF);

    idle(2);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule